// File: doc/BRIEF.md
# Double-Buffered Send FIFO

This block is the transmit-side buffer of a USB host controller. It holds two 64-byte banks. The CPU fills one bank while the packet transmitter drains the other. The CPU writes payload bytes one at a time into the current fill bank. It then writes a byte count, which hands that bank to the transmitter and moves filling to the other bank. A buffer-available flag tells the CPU whether the fill bank may be loaded.

The transmitter sees a packet-ready flag, the byte count of the bank it is sending, and a last-chunk flag. It reads bytes by offset. It ends each attempt with a done pulse that carries a success bit. A successful attempt frees the bank. A failed attempt leaves the bank, its count and its data in place, so a relaunch resends the same bytes without a reload. For isochronous payloads that span several banks, a zero count written right after a full 64-byte bank marks that bank as the end of the payload. This zero count consumes no bank.

Top module: `dbl_send_fifo`

## Requirements
- R1: After reset, `buf_avail` is 1, `tx_ready` is 0 and `fill_ovf` is 0.
- R2: Bytes written with `byte_we` are stored in order from offset 0 of the fill bank, and the transmitter reads them back at `tx_rd_addr` offsets 0 upward. The fill pointer saturates at 64, so bytes written beyond 64 are dropped. Bytes written while the fill bank is committed are dropped.
- R3: A count write (`cnt_we`) that is not a terminator, made while the fill bank is free, commits that bank. Counts above 64 are clamped to 64. The commit resets the fill pointer, switches the fill bank and raises `tx_ready`. `buf_avail` stays 1 only if the other bank is free.
- R4: `tx_done` with `tx_ok`=1 while `tx_ready` is 1 frees the bank being sent, moves sending to the other bank and sets `buf_avail` to 1.
- R5: `tx_done` with `tx_ok`=0 keeps the sending bank, its count and its data unchanged.
- R6: `tx_last` is 1 when the sending bank's count is below 64, and 0 for a 64-byte bank with no terminator.
- R7: A count of 0 written when the previous count write committed a 64-byte bank is a terminator. It sets `tx_last` on that bank if the bank is still queued. It does not switch banks, and it changes neither `buf_avail` nor `tx_count`.
- R8: A count of 0 in any other situation commits a zero-length packet: `tx_ready`=1, `tx_count`=0, `tx_last`=1.
- R9: A non-terminator count write while no bank is free is ignored and sets `fill_ovf`. `fill_ovf` stays set until an `ovf_clr` pulse. A new overflow in the same cycle as `ovf_clr` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_we | input | 1 | CPU byte write strobe |
| byte_wdata | input | 8 | CPU byte |
| cnt_we | input | 1 | Byte-count write strobe |
| cnt_wdata | input | 7 | Byte count value |
| ovf_clr | input | 1 | Write-1-to-clear for `fill_ovf` |
| buf_avail | output | 1 | Fill bank is free for loading |
| fill_ovf | output | 1 | Sticky: count write rejected |
| tx_ready | output | 1 | A committed bank awaits sending |
| tx_count | output | 7 | Byte count of the sending bank |
| tx_last | output | 1 | Sending bank ends the payload |
| tx_rd_addr | input | 6 | Byte offset in the sending bank |
| tx_rd_data | output | 8 | Byte at `tx_rd_addr` |
| tx_done | input | 1 | Send attempt finished |
| tx_ok | input | 1 | Attempt was acknowledged |

## Verification
The main function is tried with several loading patterns. Two short packets fill both banks, which tells the single-free-bank flag behaviour apart from the both-full case. A third load while both banks are full shows that both the dropped bytes and the rejected count leave the queued data alone. A 70-byte load checks pointer saturation. That load is followed by a zero count, to tell the terminator apart from a zero-length packet, and then by a short packet that must land in the next bank. A failed send followed by a successful one confirms that the retry reads identical bytes.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam int unsigned BANKS     = 2;
  localparam int unsigned DEPTH_DEF = 64;
  localparam int unsigned DATA_W    = 8;
endpackage

// File: rtl/sfifo_rst_sync.sv
module sfifo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n_sync = sh_q[1];
endmodule

// File: rtl/sfifo_bank_store.sv
module sfifo_bank_store
  import sfifo_pkg::*;
#(
  parameter int unsigned DEPTH = DEPTH_DEF,
  parameter int unsigned DW    = DATA_W,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          wbank,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rbank,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] rd_bank [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    logic          bank_we;

    assign bank_we = we && (wbank == 1'(b));

    always_ff @(posedge clk) begin
      if (bank_we) mem[waddr] <= wdata;
    end

    assign rd_bank[b] = mem[raddr];
  end

  assign rdata = rd_bank[rbank];
endmodule

// File: rtl/sfifo_bank_ctrl.sv
module sfifo_bank_ctrl
  import sfifo_pkg::*;
#(
  parameter int unsigned DEPTH = DEPTH_DEF,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_we,
  input  logic          cnt_we,
  input  logic [CW-1:0] cnt_wdata,
  input  logic          ovf_clr,
  input  logic          tx_done,
  input  logic          tx_ok,
  output logic          mem_we,
  output logic          mem_wbank,
  output logic [AW-1:0] mem_waddr,
  output logic          rd_bank,
  output logic          buf_avail,
  output logic          fill_ovf,
  output logic          tx_ready,
  output logic [CW-1:0] tx_count,
  output logic          tx_last
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic                      fill_q, fill_n, send_q, send_n;
  logic [BANKS-1:0]          full_q, full_n, term_q, term_n;
  logic [BANKS-1:0][CW-1:0]  cnt_q, cnt_n;
  logic [CW-1:0]             ptr_q, ptr_n, cnt_clamped;
  logic                      prev64_q, prev64_n, ovf_q, ovf_n;
  logic                      is_term, commit, reject, release_ok, ptr_room;

  assign cnt_clamped = (cnt_wdata > FULL_CNT) ? FULL_CNT : cnt_wdata;
  assign ptr_room    = (ptr_q < FULL_CNT);
  assign is_term     = cnt_we && (cnt_wdata == '0) && prev64_q;
  assign commit      = cnt_we && !is_term && !full_q[fill_q];
  assign reject      = cnt_we && !is_term && full_q[fill_q];
  assign release_ok  = tx_done && tx_ok && full_q[send_q];

  always_comb begin
    fill_n   = fill_q;
    send_n   = send_q;
    full_n   = full_q;
    term_n   = term_q;
    cnt_n    = cnt_q;
    ptr_n    = ptr_q;
    prev64_n = prev64_q;
    ovf_n    = ovf_q;
    if (mem_we) ptr_n = ptr_q + 1'b1;
    if (is_term) begin
      if (full_q[~fill_q]) term_n[~fill_q] = 1'b1;
      prev64_n = 1'b0;
    end
    if (release_ok) begin
      full_n[send_q] = 1'b0;
      term_n[send_q] = 1'b0;
      send_n         = ~send_q;
    end
    if (commit) begin
      full_n[fill_q] = 1'b1;
      term_n[fill_q] = 1'b0;
      cnt_n[fill_q]  = cnt_clamped;
      fill_n         = ~fill_q;
      ptr_n          = '0;
      prev64_n       = (cnt_clamped == FULL_CNT);
    end
    if (ovf_clr) ovf_n = 1'b0;
    if (reject)  ovf_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q   <= 1'b0;
      send_q   <= 1'b0;
      full_q   <= '0;
      term_q   <= '0;
      cnt_q    <= '0;
      ptr_q    <= '0;
      prev64_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      fill_q   <= fill_n;
      send_q   <= send_n;
      full_q   <= full_n;
      term_q   <= term_n;
      cnt_q    <= cnt_n;
      ptr_q    <= ptr_n;
      prev64_q <= prev64_n;
      ovf_q    <= ovf_n;
    end
  end

  assign mem_we    = byte_we && !full_q[fill_q] && ptr_room;
  assign mem_wbank = fill_q;
  assign mem_waddr = ptr_q[AW-1:0];
  assign rd_bank   = send_q;
  assign buf_avail = !full_q[fill_q];
  assign fill_ovf  = ovf_q;
  assign tx_ready  = full_q[send_q];
  assign tx_count  = cnt_q[send_q];
  assign tx_last   = term_q[send_q] || (cnt_q[send_q] != FULL_CNT);

  assert_ptr_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= FULL_CNT);
  assert_commit_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> tx_ready);
  assert_ok_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && tx_ok && tx_ready) |=> buf_avail);
  assert_nak_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !tx_ok && tx_ready) |=> (tx_ready && $stable(tx_count) && $stable(send_q)));
  assert_term_no_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_term |=> ($stable(fill_q) && $stable(buf_avail)));
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_ovf && !ovf_clr) |=> fill_ovf);
endmodule

// File: rtl/dbl_send_fifo.sv
module dbl_send_fifo
  import sfifo_pkg::*;
#(
  parameter int unsigned DEPTH = DEPTH_DEF,
  parameter int unsigned DW    = DATA_W,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_we,
  input  logic [DW-1:0] byte_wdata,
  input  logic          cnt_we,
  input  logic [CW-1:0] cnt_wdata,
  input  logic          ovf_clr,
  output logic          buf_avail,
  output logic          fill_ovf,
  output logic          tx_ready,
  output logic [CW-1:0] tx_count,
  output logic          tx_last,
  input  logic [AW-1:0] tx_rd_addr,
  output logic [DW-1:0] tx_rd_data,
  input  logic          tx_done,
  input  logic          tx_ok
);
  logic          rst_n_sync;
  logic          mem_we, mem_wbank, rd_bank;
  logic [AW-1:0] mem_waddr;

  sfifo_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  sfifo_bank_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .byte_we   (byte_we),
    .cnt_we    (cnt_we),
    .cnt_wdata (cnt_wdata),
    .ovf_clr   (ovf_clr),
    .tx_done   (tx_done),
    .tx_ok     (tx_ok),
    .mem_we    (mem_we),
    .mem_wbank (mem_wbank),
    .mem_waddr (mem_waddr),
    .rd_bank   (rd_bank),
    .buf_avail (buf_avail),
    .fill_ovf  (fill_ovf),
    .tx_ready  (tx_ready),
    .tx_count  (tx_count),
    .tx_last   (tx_last)
  );

  sfifo_bank_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .wbank (mem_wbank),
    .waddr (mem_waddr),
    .wdata (byte_wdata),
    .rbank (rd_bank),
    .raddr (tx_rd_addr),
    .rdata (tx_rd_data)
  );
endmodule

// File: tb/dbl_send_fifo_tb.sv
module dbl_send_fifo_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n;
  logic       byte_we, cnt_we, ovf_clr, tx_done, tx_ok;
  logic [7:0] byte_wdata, tx_rd_data;
  logic [6:0] cnt_wdata, tx_count;
  logic [5:0] tx_rd_addr;
  logic       buf_avail, fill_ovf, tx_ready, tx_last;

  int         n_checks = 0;
  int         n_errors = 0;
  logic [7:0] exp_q[$];

  dbl_send_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .byte_we(byte_we), .byte_wdata(byte_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .ovf_clr(ovf_clr),
    .buf_avail(buf_avail), .fill_ovf(fill_ovf), .tx_ready(tx_ready),
    .tx_count(tx_count), .tx_last(tx_last), .tx_rd_addr(tx_rd_addr),
    .tx_rd_data(tx_rd_data), .tx_done(tx_done), .tx_ok(tx_ok)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // driver: write n bytes, pushing accepted ones to the scoreboard
  task automatic load(input int n, input logic [7:0] base, input bit push);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_we    = 1'b1;
      byte_wdata = base + 8'(i);
      if (push && i < 64) exp_q.push_back(base + 8'(i));
    end
    @(negedge clk);
    byte_we = 1'b0;
  endtask

  task automatic commit(input int v);
    @(negedge clk);
    cnt_we    = 1'b1;
    cnt_wdata = 7'(v);
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  // monitor: read the sending bank, compare with the scoreboard, finish the attempt
  task automatic drain(input logic ok, input string tag);
    int n, bad;
    n   = int'(tx_count);
    bad = 0;
    check({tag, " queue depth"}, int'(exp_q.size() >= n), 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_rd_addr = 6'(i);
      #1;
      if (i < exp_q.size() && tx_rd_data !== exp_q[i]) bad++;
    end
    check({tag, " data mismatches"}, bad, 0);
    @(negedge clk);
    tx_done = 1'b1;
    tx_ok   = ok;
    if (ok) for (int i = 0; i < n && exp_q.size() > 0; i++) void'(exp_q.pop_front());
    @(negedge clk);
    tx_done = 1'b0;
    tx_ok   = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; byte_we = 1'b0; byte_wdata = '0; cnt_we = 1'b0; cnt_wdata = '0;
    ovf_clr = 1'b0; tx_done = 1'b0; tx_ok = 1'b0; tx_rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    check("R1 buf_avail after reset", int'(buf_avail), 1);
    check("R1 tx_ready after reset", int'(tx_ready), 0);
    check("R1 fill_ovf after reset", int'(fill_ovf), 0);

    load(10, 8'h10, 1'b1);
    commit(10);
    check("R3 tx_ready after commit", int'(tx_ready), 1);
    check("R3 tx_count after commit", int'(tx_count), 10);
    check("R3 buf_avail with other bank free", int'(buf_avail), 1);
    check("R6 tx_last for short bank", int'(tx_last), 1);

    load(20, 8'h40, 1'b1);
    commit(20);
    check("R3 buf_avail with both banks full", int'(buf_avail), 0);

    load(5, 8'hF0, 1'b0);  // R2: dropped, fill bank committed
    commit(7);
    check("R9 fill_ovf on rejected count", int'(fill_ovf), 1);
    check("R9 tx_count unchanged by rejected count", int'(tx_count), 10);

    drain(1'b0, "R5 first attempt");
    check("R5 tx_ready kept after failed send", int'(tx_ready), 1);
    check("R5 tx_count kept after failed send", int'(tx_count), 10);
    drain(1'b1, "R5 retry");
    check("R4 buf_avail after successful send", int'(buf_avail), 1);
    check("R4 next bank count", int'(tx_count), 20);

    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    check("R9 fill_ovf cleared by ovf_clr", int'(fill_ovf), 0);

    drain(1'b1, "R2 second bank, dropped bytes absent");
    check("R4 tx_ready after both sent", int'(tx_ready), 0);

    load(70, 8'h00, 1'b1);
    commit(100);
    check("R3 count clamped to 64", int'(tx_count), 64);
    check("R6 tx_last clear on full bank", int'(tx_last), 0);
    commit(0);
    check("R7 tx_last set by terminator", int'(tx_last), 1);
    check("R7 tx_count unchanged by terminator", int'(tx_count), 64);
    check("R7 buf_avail unchanged by terminator", int'(buf_avail), 1);
    load(3, 8'hA0, 1'b1);
    commit(3);
    check("R7 next packet took other bank", int'(buf_avail), 0);
    drain(1'b1, "R2 saturated 64-byte bank");
    check("R7 following bank count", int'(tx_count), 3);
    drain(1'b1, "R7 following bank");

    commit(0);
    check("R8 zero-length tx_ready", int'(tx_ready), 1);
    check("R8 zero-length tx_count", int'(tx_count), 0);
    check("R8 zero-length tx_last", int'(tx_last), 1);
    drain(1'b1, "R8 zero-length");
    check("R8 freed after zero-length send", int'(tx_ready), 0);

    finish_run();
  end
endmodule